// File: doc/BRIEF.md
# Processor Tick Timers with Compare Interrupt

This block holds three free-running cycle counters for one processor core: a per-core tick, a system tick and a hypervisor system tick. Each counter pairs with a compare limit. Software loads a counter value or a limit through a single write port that carries a timer select and a count/compare kind bit. Any counter can be read back at any time through a separate combinational read port. All three counters advance once for each cycle in which the shared count-enable input is high. That input stands in for the nominal 100 MHz tick rate.

The top bit of each 64-bit word is not part of the value. It is one disable flag per timer, and both count writes and compare writes update it. A read returns that flag in bit 63. A compare write with a nonzero limit and a clear flag arms a one-shot match. When the counter reaches the limit, the timer sets its bit in a soft-interrupt pending vector and pulses a wake output toward a halted core. The per-core tick uses bit 0. The system and hypervisor ticks share bit 16. Pending bits are cleared with a write-one-to-clear strobe.

Top module: `cpu_tick_timers`

## Requirements
- R1: After reset every pending bit and `wake` are 0, and each timer reads `64'h8000_0000_0000_0000`: count 0 with the disable flag set.
- R2: On each cycle with `cnt_en` high and no count write to that timer, its count rises by one. With `cnt_en` low the count holds.
- R3: A count write (`wr_cmp`=0) loads `wr_data[62:0]` as the count and `wr_data[63]` as the disable flag. From the next cycle, a read (`rd_sel` 0 per-core, 1 system, 2 hypervisor, 3 reads zero) returns the count in bits 62:0 and the flag in bit 63.
- R4: A compare write (`wr_cmp`=1) loads `wr_data[62:0]` as the limit and writes `wr_data[63]` into the same disable flag that count writes use.
- R5: The count keeps advancing while the disable flag is set.
- R6: After an arming compare write with limit L while the count is C, the match occurs on count tick number max(1, L−C). A limit at or below the current count therefore fires on the first tick.
- R7: A compare write whose limit is zero or whose bit 63 is set cancels any armed match and arms nothing.
- R8: A match consumes the arming. No further match occurs until the next compare write.
- R9: A match sets pending bit 0 for the per-core tick and pending bit 16 for the system and hypervisor ticks. The bit is visible in the cycle after the matching tick edge.
- R10: `wake` is high for exactly the one cycle after each edge at which an enabled match occurs.
- R11: If the disable flag is set when the count reaches the limit, no pending bit is set and `wake` stays low. The arming is still consumed, so clearing the flag afterwards does not bring the match back.
- R12: A one in `si_clr` clears that pending bit. When a set and a clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick enable shared by all three timers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Timer select for writes (0 core, 1 system, 2 hypervisor) |
| wr_cmp | input | 1 | 0 = count write, 1 = compare write |
| wr_data | input | 64 | Write data; bit 63 is the disable flag |
| rd_sel | input | 2 | Timer select for reads |
| rd_data | output | 64 | Selected count with the disable flag in bit 63 |
| si_clr | input | 32 | Write-one-to-clear strobe for the pending bits |
| si_pend | output | 32 | Soft-interrupt pending bits |
| wake | output | 1 | One-cycle wake pulse on each enabled match |

## Verification
The hardest situations to reach from the ports are a match that arrives while the timer is disabled, and a match that collides with a clear of its own pending bit. Both depend on where the match lands in time. The stimulus controls that by freezing `cnt_en` while it writes the count and then the limit. The tick on which the match falls is then exactly max(1, L−C) after counting resumes. For the collision, the clear strobe is placed on that tick. For the disabled case, the flag is raised by a count write before the limit is reached, and the bench checks that clearing the flag later produces no late interrupt. A sweep over all three timers and limits from below to above the current count checks the tick on which each match arrives.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int NUM_TMR = 3;
  localparam int SI_CORE_BIT = 0;
  localparam int SI_SYS_BIT  = 16;

  typedef enum logic [1:0] {
    TMR_CORE = 2'd0,
    TMR_SYS  = 2'd1,
    TMR_HYP  = 2'd2
  } tmr_id_e;

  // Pending bit that a given timer index drives (R9)
  function automatic int si_bit_of(input int id);
    return (id == int'(TMR_CORE)) ? SI_CORE_BIT : SI_SYS_BIT;
  endfunction
endpackage

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_cnt,
  input  logic             wr_lim,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int VAL_W = CNT_W - 1;

  logic [VAL_W-1:0] val_q, lim_q;
  logic             dis_q, arm_q;
  logic [VAL_W-1:0] val_inc;
  logic             match;
  logic             new_arm;

  // Count after this tick has reached the limit
  function automatic logic reaches(input logic [VAL_W-1:0] nxt,
                                   input logic [VAL_W-1:0] lim);
    return nxt >= lim;
  endfunction

  assign val_inc = val_q + 1'b1;
  assign match   = cnt_en && !wr_cnt && !wr_lim && arm_q && reaches(val_inc, lim_q);
  assign irq     = match && !dis_q;
  assign new_arm = (wr_data[VAL_W-1:0] != '0) && !wr_data[CNT_W-1];
  assign rd_data = {dis_q, val_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      lim_q <= '0;
      dis_q <= 1'b1;
      arm_q <= 1'b0;
    end else begin
      if (wr_cnt) begin
        val_q <= wr_data[VAL_W-1:0];
        dis_q <= wr_data[CNT_W-1];
      end else if (cnt_en) begin
        val_q <= val_inc;
      end
      if (wr_lim) begin
        lim_q <= wr_data[VAL_W-1:0];
        dis_q <= wr_data[CNT_W-1];
        arm_q <= new_arm;
      end else if (match) begin
        arm_q <= 1'b0;
      end
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_cnt) |=> (rd_data[VAL_W-1:0] == $past(rd_data[VAL_W-1:0]) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt) |=> $stable(rd_data[VAL_W-1:0]));

  a_r3_read_fold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (rd_data == $past(wr_data)));

  a_r7_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim && !new_arm) |=> !arm_q);

  a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !arm_q);
endmodule

// File: rtl/softint_reg.sv
module softint_reg #(
  parameter int SI_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SI_W-1:0] set,
  input  logic [SI_W-1:0] clr,
  output logic [SI_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set & clr) != '0) |=> ((q & $past(set & clr)) == $past(set & clr)));

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/cpu_tick_timers.sv
module cpu_tick_timers #(
  parameter int CNT_W = 64,
  parameter int SI_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic [SI_W-1:0]  si_clr,
  output logic [SI_W-1:0]  si_pend,
  output logic             wake
);
  import tick_pkg::*;

  localparam int NT = NUM_TMR;

  logic [CNT_W-1:0] rd_vec [NT];
  logic [NT-1:0]    irq_vec;
  logic [SI_W-1:0]  si_set;
  logic             wake_q;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic sel_hit;
    assign sel_hit = wr_en && (wr_sel == 2'(g));
    tick_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .wr_cnt  (sel_hit && !wr_cmp),
      .wr_lim  (sel_hit && wr_cmp),
      .wr_data (wr_data),
      .rd_data (rd_vec[g]),
      .irq     (irq_vec[g])
    );
  end

  always_comb begin
    si_set = '0;
    for (int i = 0; i < NT; i++)
      if (irq_vec[i]) si_set[si_bit_of(i)] = 1'b1;
  end

  softint_reg #(.SI_W(SI_W)) u_si (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (si_set),
    .clr   (si_clr),
    .q     (si_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |irq_vec;
  end
  assign wake = wake_q;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = rd_vec[0];
      2'd1:    rd_data = rd_vec[1];
      2'd2:    rd_data = rd_vec[2];
      default: rd_data = '0;
    endcase
  end

  a_r10_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_vec) |=> wake);

  a_r10_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_vec) |=> !wake);

  a_r9_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[0] |=> si_pend[SI_CORE_BIT]);
endmodule

// File: tb/tb_cpu_tick_timers.sv
module tb_cpu_tick_timers;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_cmp = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [31:0] si_clr = '0;
  logic [31:0] si_pend;
  logic        wake;

  int n_chk = 0;
  int n_bad = 0;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  always #2 clk = ~clk;

  cpu_tick_timers dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sib(input int t);
    return (t == 0) ? 0 : 16;
  endfunction

  task automatic wr(input int t, input logic cmp, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(t); wr_cmp = cmp; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk);
    si_clr = '1;
    @(negedge clk);
    si_clr = '0;
  endtask

  // Run ticks until pending bit appears or max ticks; returns tick count (0 = none)
  task automatic run_until(input int t, input int maxn, output int got, output logic wk);
    got = 0; wk = 1'b0;
    cnt_en = 1'b1;
    for (int n = 1; n <= maxn; n++) begin
      @(negedge clk);
      if (si_pend[sib(t)] && got == 0) begin got = n; wk = wake; end
    end
    cnt_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int got; logic wk; int k;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pend", {32'd0, si_pend}, 64'd0);
    check("R1 wake", {63'd0, wake}, 64'd0);
    for (int t = 0; t < 3; t++) begin
      rd_sel = 2'(t); #0;
      check("R1 read", rd_data, DIS);
    end
    rd_sel = 2'd3; #1;
    check("R3 sel3 zero", rd_data, 64'd0);

    // R2 / R5: counting while disabled, hold when cnt_en low
    cnt_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_en = 1'b0;
    for (int t = 0; t < 3; t++) begin
      rd_sel = 2'(t); #1;
      check("R5 count while disabled", rd_data, DIS | 64'd7);
    end
    repeat (3) @(negedge clk);
    rd_sel = 0; #1;
    check("R2 hold", rd_data, DIS | 64'd7);

    // R3 count write, flag fold
    wr(1, 1'b0, 64'h0000_0000_1234_5678);
    rd_sel = 1; #1;
    check("R3 enabled read", rd_data, 64'h1234_5678);
    wr(1, 1'b0, DIS | 64'h55);
    #1 check("R3 disabled read", rd_data, DIS | 64'h55);
    // R4 compare write updates the shared flag
    wr(1, 1'b1, 64'd0);
    #1 check("R4 cmp clears flag", rd_data, 64'h55);
    wr(1, 1'b1, DIS | 64'd3);
    #1 check("R4 cmp sets flag", rd_data, DIS | 64'h55);

    // R6 / R9 / R10 / R8 sweep
    for (int t = 0; t < 3; t++) begin
      for (int ci = 0; ci < 2; ci++) begin
        c = (ci == 0) ? 64'd40 : 64'h0000_7FFF_FFFF_FF00;
        for (int dl = -3; dl <= 6; dl++) begin
          wr(t, 1'b0, c);
          wr(t, 1'b1, c + 64'(dl));
          k = (dl < 1) ? 1 : dl;
          run_until(t, 10, got, wk);
          check($sformatf("R6 t%0d d%0d tick", t, dl), 64'(got), 64'(k));
          check("R10 wake with match", {63'd0, wk}, 64'd1);
          check("R9 bit map", {32'd0, si_pend}, 64'(32'd1 << sib(t)));
          clr_all();
          run_until(t, 6, got, wk);
          check("R8 one-shot", 64'(got), 64'd0);
          check("R10 no wake", {63'd0, wake}, 64'd0);
        end
      end
    end

    // R7 zero limit and disabled compare arm nothing, and cancel armed
    wr(0, 1'b0, 64'd10);
    wr(0, 1'b1, 64'd0);
    run_until(0, 8, got, wk);
    check("R7 zero limit", 64'(got), 64'd0);
    wr(0, 1'b0, 64'd10);
    wr(0, 1'b1, 64'd12);
    wr(0, 1'b1, DIS | 64'd12);
    run_until(0, 8, got, wk);
    check("R7 disabled cmp cancels", 64'(got), 64'd0);

    // R11 match while disabled is consumed
    wr(2, 1'b0, 64'd100);
    wr(2, 1'b1, 64'd103);
    wr(2, 1'b0, DIS | 64'd100);
    run_until(2, 6, got, wk);
    check("R11 no pend disabled", 64'(got), 64'd0);
    wr(2, 1'b0, 64'd100);
    run_until(2, 6, got, wk);
    check("R11 arm consumed", 64'(got), 64'd0);

    // R12 set wins over same-cycle clear, then clear alone
    clr_all();
    wr(0, 1'b0, 64'd5);
    wr(0, 1'b1, 64'd6);
    @(negedge clk);
    cnt_en = 1'b1; si_clr = 32'h1;
    @(negedge clk);
    cnt_en = 1'b0; si_clr = '0;
    check("R12 set wins", {63'd0, si_pend[0]}, 64'd1);
    @(negedge clk);
    si_clr = 32'h1;
    @(negedge clk);
    si_clr = '0;
    check("R12 clear", {32'd0, si_pend}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule